// File: doc/BRIEF.md
# Serial Bias Supply Control Register Interface

This block is the digital control core of an adjustable display bias supply. It is a two-wire serial slave (SMBus signalling, open-drain data line) that holds everything the analog section needs: a 5-bit output-level code and two small configuration registers. Each configuration register carries a run bit and a panel-enable bit. The block samples both serial lines, the suspend pin and the power-good level with its own clock, and it drives a pull-low request for the shared data line.

A write transaction carries one data byte. That byte is a complete update. Its low five bits always load the level code. Its top bit picks which configuration register takes the run and panel-enable bits. There is no command byte. The suspend pin selects which configuration register drives the outputs, so firmware can prepare a suspend profile ahead of time. The level code is shared by both profiles. A read transaction returns one status byte.

Top module: `bias_smb_ctrl`

## Requirements
- R1: The block acknowledges only the 7-bit address 0101100. A transaction to any other address gets no acknowledge, and its data bytes change no state.
- R2: Every data byte of a write loads its bits 4:0 into the level code, including the end values 00000 and 11111.
- R3: Bit 7 of the data byte selects the target configuration register: 0 selects the suspend profile and 1 selects the operate profile. Bit 6 is written as the run bit and bit 5 as the panel-enable bit. The other profile is left unchanged.
- R4: While the suspend pin is high, the operate profile drives `run_o` and the panel enable. While it is low, the suspend profile drives them.
- R5: An active run bit of 0 drives `run_o` low (shutdown). The serial interface keeps acknowledging and accepting writes in shutdown, so a later write can set the run bit back to 1.
- R6: The level code keeps its value across shutdown and across changes of the suspend pin. Only a data byte changes it.
- R7: `panel_en_o` is low whenever the power-good input is low, whatever the stored panel-enable bits hold.
- R8: Reset sets the level code to 10000 (mid-scale). It sets both profiles to run = 1 and panel-enable = 0.
- R9: A read returns one status byte: bit 7 is the active run bit, bit 6 is the active stored panel-enable bit (not gated by power-good), bit 5 is the suspend pin, bit 4 is power-good, and bits 3:0 are 0.
- R10: The block pulls the data line low only in the acknowledge slot after a matched address or a written data byte, and in the bit slots of a status byte it is sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it samples the serial lines |
| rst_n | input | 1 | Active-low power-up / undervoltage reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (as seen on the shared wire) |
| sda_pull_o | output | 1 | When high, the open-drain driver pulls the data line low |
| sus_pin_i | input | 1 | Suspend pin: high selects the operate profile, low selects the suspend profile |
| pwr_ok_i | input | 1 | Digital power-good level |
| run_o | output | 1 | Active run bit; low means shutdown |
| panel_en_o | output | 1 | Active panel enable, gated by power-good |
| dac_code_o | output | 5 | Output-level code for the bias DAC |

## Verification
The bench targets the profile crossover. It writes one profile while the other is live, then flips the suspend pin. A design that decoded bit 7 backwards, or picked the profile by the wrong pin polarity, would show the wrong run or panel state after the flip. It drives the design into shutdown through the serial bus and then brings it out with another write. A design that gated the interface with the run bit would stop acknowledging and stay shut down. Other checks cover the level code after shutdown and after profile swaps, which it must keep; the foreign address, which must get no acknowledge and change no state; and the status byte under low power-good. In that byte the stored panel bit must still read 1 while the panel output is forced low.

// File: rtl/bias_smb_pkg.sv
package bias_smb_pkg;

  // one profile: run (1 = running, 0 = shutdown) and panel enable
  typedef struct packed {
    logic run;
    logic pnl;
  } prof_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_DACK,
    ST_RDAT,
    ST_RACK
  } smb_st_e;

  // data byte field positions (the bench decodes these too)
  localparam int unsigned SEL_POS = 7;
  localparam int unsigned RUN_POS = 6;
  localparam int unsigned PNL_POS = 5;
  localparam int unsigned LVL_W   = 5;

  localparam prof_t PROF_RST = '{run: 1'b1, pnl: 1'b0};

  function automatic prof_t byte_to_prof(input logic [7:0] b);
    prof_t p;
    p.run = b[RUN_POS];
    p.pnl = b[PNL_POS];
    return p;
  endfunction

  function automatic logic byte_sel_opr(input logic [7:0] b);
    return b[SEL_POS];
  endfunction

  function automatic logic [LVL_W-1:0] byte_level(input logic [7:0] b);
    return b[LVL_W-1:0];
  endfunction

  function automatic logic [7:0] status_pack(input prof_t act, input logic sus,
                                             input logic pok);
    return {act.run, act.pnl, sus, pok, 4'b0000};
  endfunction

endpackage

// File: rtl/bias_smb_sync.sv
module bias_smb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s] <= RST_VAL;
      end else if (s == 0) begin
        chain[s] <= d_i;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/bias_smb_link.sv
module bias_smb_link
  import bias_smb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b0101100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] status_byte,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       sda_pull,
  output logic       addr_reject,
  output logic       ack_slot,
  output logic       tx_slot
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic    scl_prev, sda_prev;
  logic    scl_rise, scl_fall, start_ev, stop_ev;
  smb_st_e st;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sr, tx_sr;
  logic       rd_mode, master_ack;
  logic       byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_ev  = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev   = scl_s & scl_prev & ~sda_prev & sda_s;
  assign byte_done = scl_fall && (bit_cnt == BITS_PER_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      rd_mode     <= 1'b0;
      master_ack  <= 1'b0;
      sda_pull    <= 1'b0;
      wr_stb      <= 1'b0;
      wr_byte     <= '0;
      addr_reject <= 1'b0;
    end else begin
      wr_stb      <= 1'b0;
      addr_reject <= 1'b0;
      if (start_ev) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sr   <= {rx_sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              if (rx_sr[7:1] == SLV_ADDR) begin
                rd_mode  <= rx_sr[0];
                sda_pull <= 1'b1;
                st       <= ST_AACK;
              end else begin
                addr_reject <= 1'b1;
                st          <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx_sr    <= status_byte;
                sda_pull <= ~status_byte[7];
                st       <= ST_RDAT;
              end else begin
                sda_pull <= 1'b0;
                st       <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              rx_sr   <= {rx_sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              wr_stb   <= 1'b1;
              wr_byte  <= rx_sr;
              sda_pull <= 1'b1;
              st       <= ST_DACK;
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              st       <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              sda_pull <= 1'b0;
              st       <= ST_RACK;
            end else if (scl_fall) begin
              tx_sr    <= {tx_sr[6:0], 1'b0};
              sda_pull <= ~tx_sr[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                bit_cnt  <= '0;
                tx_sr    <= status_byte;
                sda_pull <= ~status_byte[7];
                st       <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign ack_slot = (st == ST_AACK) || (st == ST_DACK);
  assign tx_slot  = (st == ST_RDAT);

endmodule

// File: rtl/bias_prof_regs.sv
module bias_prof_regs
  import bias_smb_pkg::*;
#(
  parameter int unsigned DAC_W = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [7:0]       wr_byte,
  input  logic             sus_s,
  input  logic             pok_s,
  output logic [DAC_W-1:0] dac_code,
  output prof_t            opr_prof,
  output prof_t            sus_prof,
  output prof_t            act_prof,
  output logic             run_q,
  output logic             pnl_q
);

  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= DAC_MID;
      opr_prof <= PROF_RST;
      sus_prof <= PROF_RST;
    end else if (wr_stb) begin
      dac_code <= DAC_W'(byte_level(wr_byte));
      if (byte_sel_opr(wr_byte)) opr_prof <= byte_to_prof(wr_byte);
      else                       sus_prof <= byte_to_prof(wr_byte);
    end
  end

  assign act_prof = sus_s ? opr_prof : sus_prof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= PROF_RST.run;
      pnl_q <= 1'b0;
    end else begin
      run_q <= act_prof.run;
      pnl_q <= act_prof.pnl & pok_s;
    end
  end

endmodule

// File: rtl/bias_smb_ctrl.sv
module bias_smb_ctrl
  import bias_smb_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR    = 7'b0101100,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DAC_W       = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic             sus_pin_i,
  input  logic             pwr_ok_i,
  output logic             run_o,
  output logic             panel_en_o,
  output logic [DAC_W-1:0] dac_code_o
);

  localparam int unsigned N_SYNC = 4;

  logic [N_SYNC-1:0] raw_in, synced;
  logic  scl_s, sda_s, sus_s, pok_s;
  logic  wr_stb, addr_reject, ack_slot, tx_slot;
  logic [7:0] wr_byte, status_byte;
  prof_t opr_prof, sus_prof, act_prof;

  assign raw_in = {scl_i, sda_i, sus_pin_i, pwr_ok_i};

  bias_smb_sync #(
    .WIDTH  (N_SYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (synced)
  );

  assign {scl_s, sda_s, sus_s, pok_s} = synced;

  assign status_byte = status_pack(act_prof, sus_s, pok_s);

  bias_smb_link #(
    .SLV_ADDR(SLV_ADDR)
  ) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .status_byte(status_byte),
    .wr_stb     (wr_stb),
    .wr_byte    (wr_byte),
    .sda_pull   (sda_pull_o),
    .addr_reject(addr_reject),
    .ack_slot   (ack_slot),
    .tx_slot    (tx_slot)
  );

  bias_prof_regs #(
    .DAC_W(DAC_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .sus_s   (sus_s),
    .pok_s   (pok_s),
    .dac_code(dac_code_o),
    .opr_prof(opr_prof),
    .sus_prof(sus_prof),
    .act_prof(act_prof),
    .run_q   (run_o),
    .pnl_q   (panel_en_o)
  );

endmodule

// File: rtl/bias_smb_ctrl_chk.sv
module bias_smb_ctrl_chk
  import bias_smb_pkg::*;
#(
  parameter int unsigned DAC_W = LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             sda_pull_o,
  input logic             addr_reject,
  input logic             ack_slot,
  input logic             tx_slot,
  input logic             sus_s,
  input logic             pok_s,
  input prof_t            opr_prof,
  input prof_t            sus_prof,
  input logic             run_o,
  input logic             panel_en_o,
  input logic [DAC_W-1:0] dac_code_o
);

  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W-1);

  AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_code_o == MID)); // R8

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(dac_code_o)); // R6

  AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reject |=> !sda_pull_o); // R1

  AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (ack_slot || tx_slot)); // R10

  AST_PANEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pok_s |=> !panel_en_o); // R7

  AST_OPR_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (sus_s && !opr_prof.run) |=> !run_o); // R4

  AST_SUS_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sus_s && !sus_prof.run) |=> !run_o); // R5

endmodule

bind bias_smb_ctrl bias_smb_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .sda_pull_o (sda_pull_o),
  .addr_reject(addr_reject),
  .ack_slot   (ack_slot),
  .tx_slot    (tx_slot),
  .sus_s      (sus_s),
  .pok_s      (pok_s),
  .opr_prof   (opr_prof),
  .sus_prof   (sus_prof),
  .run_o      (run_o),
  .panel_en_o (panel_en_o),
  .dac_code_o (dac_code_o)
);

// File: tb/bias_smb_ctrl_tb.sv
module bias_smb_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam logic [6:0] MY_ADDR = 7'b0101100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sus_pin = 1'b1;
  logic pwr_ok = 1'b1;
  logic sda_pull;
  logic sda;
  logic run;
  logic panel;
  logic [4:0] dac;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda = ~(m_low | sda_pull);

  bias_smb_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda),
    .sda_pull_o(sda_pull),
    .sus_pin_i (sus_pin),
    .pwr_ok_i  (pwr_ok),
    .run_o     (run),
    .panel_en_o(panel),
    .dac_code_o(dac)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; scl = 1'b1; wq();
    m_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; m_low = 1'b1; wq();
    scl = 1'b1; wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq();
    scl = 1'b1; wq();
    b = sda; wq();
    scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic bus_write(input logic [6:0] addr, input logic [7:0] data,
                           output logic a_ack, output logic d_ack);
    bus_start();
    put_byte({addr, 1'b0}, a_ack);
    put_byte(data, d_ack);
    bus_stop();
  endtask

  task automatic bus_read(input logic [6:0] addr, output logic a_ack,
                          output logic [7:0] v);
    logic b;
    bus_start();
    put_byte({addr, 1'b1}, a_ack);
    v = '0;
    if (a_ack) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(b);
        v[i] = b;
      end
      put_bit(1'b1);
    end
    bus_stop();
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  // each data byte: bit7 = profile select, bit6 = run, bit5 = panel, 4:0 = level
  task automatic t_reset();
    logic a; logic [7:0] s;
    chk("R8 level after reset", dac, 5'b10000);
    chk("R8 run after reset", run, 1);
    chk("R8 panel after reset", panel, 0);
    chk("R10 idle line released", sda_pull, 0);
    bus_read(MY_ADDR, a, s);
    chk("R9 read address ack", a, 1);
    chk("R9 status after reset", s, 8'hB0);
  endtask

  task automatic t_foreign();
    logic a, d;
    bus_write(7'b0101101, 8'hE5, a, d);
    settle();
    chk("R1 foreign address nack", a, 0);
    chk("R1 foreign write level unchanged", dac, 5'b10000);
    chk("R1 foreign write panel unchanged", panel, 0);
  endtask

  task automatic t_opr_write();
    logic a, d;
    bus_write(MY_ADDR, 8'hE5, a, d);
    settle();
    chk("R10 address ack", a, 1);
    chk("R10 data ack", d, 1);
    chk("R2 level loaded", dac, 5'd5);
    chk("R3 operate profile run", run, 1);
    chk("R3 operate profile panel", panel, 1);
  endtask

  task automatic t_swap_profile();
    logic a; logic [7:0] s;
    sus_pin = 1'b0; settle();
    chk("R4 suspend profile run", run, 1);
    chk("R4 suspend profile panel untouched", panel, 0);
    chk("R6 level kept across swap", dac, 5'd5);
    bus_read(MY_ADDR, a, s);
    chk("R9 status in suspend", s, 8'h90);
  endtask

  task automatic t_shutdown_cycle();
    logic a, d;
    bus_write(MY_ADDR, 8'h3F, a, d);
    settle();
    chk("R5 shutdown via suspend profile", run, 0);
    chk("R3 suspend profile panel", panel, 1);
    chk("R2 level full scale", dac, 5'd31);
    bus_write(MY_ADDR, 8'h5F, a, d);
    settle();
    chk("R5 ack while shut down", a & d, 1);
    chk("R5 run restored", run, 1);
    chk("R6 level kept after shutdown", dac, 5'd31);
    sus_pin = 1'b1; settle();
    chk("R4 operate profile back", {run, panel}, 2'b11);
    chk("R6 level kept after swap back", dac, 5'd31);
  endtask

  task automatic t_power_good();
    logic a, d; logic [7:0] s;
    pwr_ok = 1'b0; settle();
    chk("R7 panel off at low power-good", panel, 0);
    bus_read(MY_ADDR, a, s);
    chk("R9 status with low power-good", s, 8'hE0);
    pwr_ok = 1'b1; settle();
    chk("R7 panel back on", panel, 1);
    bus_write(MY_ADDR, 8'hE0, a, d);
    settle();
    chk("R2 level zero", dac, 5'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_foreign();
    t_opr_write();
    t_swap_profile();
    t_shutdown_cycle();
    t_power_good();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule